// File: doc/BRIEF.md
# Conditional 16-bit Arithmetic Unit

This block executes one arithmetic or logic instruction at a time on two 16-bit sources and returns a registered result. A 4-bit opcode selects among sixteen operations. Opcode 0001 is a gateway to single-source operations, and an 8-bit sub-code chooses among them. Every instruction carries a 4-bit condition field. Its upper three bits name a test on the stored status flags, and the result write is enabled only when that test holds. Its low bit asks for the status flags to be refreshed from the instruction's result, and that refresh happens whether or not the test holds.

Most operations finish one cycle after they are accepted. Unsigned divide and modulo run through an iterative divider, which holds `busy_o` high until it completes. Division by zero gives defined values and raises an error pulse. The surrounding pipeline fetches the operands, delivers the result to the destination when `wr_en_o` is high, and waits for `done_o` before issuing the next instruction.

Top module: `cond_alu16`

## Requirements
- R1: Under reset, `result_o` is 0, `flags_o` is 0, and `wr_en_o`, `done_o`, `busy_o` and `div_err_o` are low.
- R2: An instruction accepted with `valid_i` high while `busy_o` is low, with an opcode below 1110, raises `done_o` for exactly one cycle on the next clock edge, together with its result. `busy_o` stays low for such an instruction.
- R3: The opcodes compute the following, taking a = `src_a_i` and b = `src_b_i`:
  - 0000 passes a through as a constant.
  - 0010 is a OR b, 0011 is a AND b, and 0100 is a XOR b.
  - 1001 is a+b and 1010 is a-b, both modulo 2^16.
  - 1011 is the low 16 bits of a*b.
  - 1100 is the high 16 bits of the signed product.
  - 1101 is the high 16 bits of the unsigned product.
- R4: The shift amount is `src_b_i[3:0]`, and the upper bits of `src_b_i` are ignored. Opcode 0101 is a logical right shift, 0110 an arithmetic right shift, 0111 a left shift that fills with zeros, and 1000 a left rotate.
- R5: Under opcode 0001, sub-code 0x01 gives ~a, 0x02 gives -a, and 0x03 gives 1 when a is zero and 0 otherwise. Sub-codes 0x04 to 0xFF produce no write and leave the flags unchanged.
- R6: Opcode 0001 with sub-code 0x00 is a compare. It sets `flags_o[1]` to signed a<b and `flags_o[0]` to a==b, whatever the condition field holds, and it never raises `wr_en_o`.
- R7: `cond_i[3:1]` selects the test on the stored flags (lt = `flags_o[1]`, eq = `flags_o[0]`):
  - 000 always passes.
  - 001 passes on lt, 010 on lt or eq, and 011 on eq.
  - 100 passes on not lt, 101 on neither lt nor eq, and 110 on not eq.
  - 111 never passes.
  - `wr_en_o` is high only when the test passes.
- R8: With `cond_i[0]` set, the flags are refreshed from the result (lt = result bit 15, eq = result is zero), whether or not the test passes. With `cond_i[0]` clear, the flags hold.
- R9: Opcode 1110 gives the unsigned quotient and 1111 the unsigned remainder. `busy_o` is high from the cycle after acceptance until `done_o`, and the condition is tested when the operation completes.
- R10: When the divisor is zero, the quotient is 0xFFFF and the remainder is the dividend, and `div_err_o` is high together with `done_o`.
- R11: `valid_i` is ignored while `busy_o` is high. An instruction offered during that time produces no completion and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction offered this cycle |
| op_i | input | 4 | Primary opcode |
| cond_i | input | 4 | Condition test in [3:1], flag refresh in [0] |
| sub_i | input | 8 | Sub-code for opcode 0001 |
| src_a_i | input | 16 | First source, or constant |
| src_b_i | input | 16 | Second source, or shift amount |
| result_o | output | 16 | Registered result |
| wr_en_o | output | 1 | Result write enable, valid with done_o |
| done_o | output | 1 | Instruction completed |
| busy_o | output | 1 | Divider in progress |
| div_err_o | output | 1 | Division by zero, valid with done_o |
| flags_o | output | 2 | Stored flags {lt, eq} |

## Verification
The hardest case to reach is a conditional write whose outcome depends on flags left behind by an earlier instruction. This is hardest of all across a multi-cycle division, where other instructions are offered while the divider runs. The bench sweeps every opcode, every condition value and every sub-code of interest over a grid of corner operands, including 0x8000, 0x7FFF, 0xFFFF and zero divisors. In that sweep each instruction inherits the flags its predecessor left, so every condition code meets both flag states. It then starts a divide and offers a flag-refreshing load while the divider is busy, to show that the offered instruction leaves no trace.

// File: rtl/calu_pkg.sv
package calu_pkg;
  typedef enum logic [3:0] {
    OP_CONST = 4'd0,  OP_UNARY = 4'd1,  OP_OR    = 4'd2,  OP_AND   = 4'd3,
    OP_XOR   = 4'd4,  OP_SHR   = 4'd5,  OP_SAR   = 4'd6,  OP_SHL   = 4'd7,
    OP_ROL   = 4'd8,  OP_ADD   = 4'd9,  OP_SUB   = 4'd10, OP_MULLO = 4'd11,
    OP_MULHS = 4'd12, OP_MULHU = 4'd13, OP_DIV   = 4'd14, OP_MOD   = 4'd15
  } op_e;

  localparam logic [7:0] SUB_CMP  = 8'h00;
  localparam logic [7:0] SUB_NOT  = 8'h01;
  localparam logic [7:0] SUB_NEG  = 8'h02;
  localparam logic [7:0] SUB_LNOT = 8'h03;

  typedef struct packed {
    logic lt;
    logic eq;
  } flags_t;
endpackage

// File: rtl/calu_logic.sv
module calu_logic
  import calu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  op_e          op_i,
  input  logic [7:0]   sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         writes_o,
  output logic         cmp_o,
  output logic         legal_o
);
  localparam int unsigned SHW = $clog2(W);

  logic [SHW-1:0] amt;
  logic [SHW:0]   ramt;
  logic [2*W-1:0] prod_u, prod_s;

  assign amt    = b_i[SHW-1:0];
  assign ramt   = (SHW+1)'(W) - {1'b0, amt};
  assign prod_u = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
  assign prod_s = {{W{a_i[W-1]}}, a_i} * {{W{b_i[W-1]}}, b_i};

  always_comb begin
    res_o    = '0;
    writes_o = 1'b1;
    cmp_o    = 1'b0;
    legal_o  = 1'b1;
    unique case (op_i)
      OP_CONST: res_o = a_i;
      OP_UNARY: begin
        unique case (sub_i)
          SUB_CMP: begin
            cmp_o    = 1'b1;
            writes_o = 1'b0;
          end
          SUB_NOT:  res_o = ~a_i;
          SUB_NEG:  res_o = '0 - a_i;
          SUB_LNOT: res_o = W'(a_i == '0);
          default: begin
            writes_o = 1'b0;
            legal_o  = 1'b0;
          end
        endcase
      end
      OP_OR:    res_o = a_i | b_i;
      OP_AND:   res_o = a_i & b_i;
      OP_XOR:   res_o = a_i ^ b_i;
      OP_SHR:   res_o = a_i >> amt;
      OP_SAR:   res_o = W'($signed(a_i) >>> amt);
      OP_SHL:   res_o = a_i << amt;
      OP_ROL:   res_o = (a_i << amt) | (a_i >> ramt);
      OP_ADD:   res_o = a_i + b_i;
      OP_SUB:   res_o = a_i - b_i;
      OP_MULLO: res_o = prod_u[W-1:0];
      OP_MULHS: res_o = prod_s[2*W-1:W];
      OP_MULHU: res_o = prod_u[2*W-1:W];
      default: begin
        writes_o = 1'b0;
        legal_o  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/calu_cond.sv
module calu_cond
  import calu_pkg::*;
(
  input  logic [2:0] sel_i,
  input  flags_t     flags_i,
  output logic       pass_o
);
  always_comb begin
    unique case (sel_i)
      3'd0:    pass_o = 1'b1;
      3'd1:    pass_o = flags_i.lt;
      3'd2:    pass_o = flags_i.lt | flags_i.eq;
      3'd3:    pass_o = flags_i.eq;
      3'd4:    pass_o = ~flags_i.lt;
      3'd5:    pass_o = ~flags_i.lt & ~flags_i.eq;
      3'd6:    pass_o = ~flags_i.eq;
      default: pass_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/calu_divider.sv
module calu_divider #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         fin_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic          run_q, fin_q;
  logic [W:0]    trial, diff;
  logic          fits;

  // restoring step; divisor 0 always fits -> all-ones quotient, dividend remainder
  assign trial = {rem_q, quo_q[W-1]};
  assign diff  = trial - {1'b0, dvs_q};
  assign fits  = trial >= {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CW'(W);
      rem_q <= '0;
      quo_q <= dividend_i;
      dvs_q <= divisor_i;
      run_q <= 1'b1;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (run_q) begin
        rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign fin_o  = fin_q;
  assign quot_o = quo_q;
  assign rem_o  = rem_q;
endmodule

// File: rtl/cond_alu16.sv
module cond_alu16
  import calu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [3:0]   cond_i,
  input  logic [7:0]   sub_i,
  input  logic [W-1:0] src_a_i,
  input  logic [W-1:0] src_b_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic         done_o,
  output logic         busy_o,
  output logic         div_err_o,
  output logic [1:0]   flags_o
);
  op_e          op;
  logic         is_div, accept, div_fin;
  logic [W-1:0] res_l, quot, rem;
  logic         writes_l, cmp_l, legal_l, pass;
  logic [2:0]   sel;

  logic         busy_q, done_q, wr_q, err_q;
  logic [W-1:0] res_q;
  flags_t       flags_q, flags_n;
  logic [3:0]   p_cond_q;
  logic         p_mod_q, p_dz_q;

  logic         f_done, f_wr, f_upd, f_err;
  logic [W-1:0] f_res;

  assign op     = op_e'(op_i);
  assign is_div = (op == OP_DIV) || (op == OP_MOD);
  assign accept = valid_i && !busy_q;

  calu_logic #(.W(W)) u_logic (
    .op_i    (op),
    .sub_i   (sub_i),
    .a_i     (src_a_i),
    .b_i     (src_b_i),
    .res_o   (res_l),
    .writes_o(writes_l),
    .cmp_o   (cmp_l),
    .legal_o (legal_l)
  );

  calu_divider #(.W(W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept && is_div),
    .dividend_i(src_a_i),
    .divisor_i (src_b_i),
    .fin_o     (div_fin),
    .quot_o    (quot),
    .rem_o     (rem)
  );

  // divide completes while busy, so the test takes the held condition
  assign sel = div_fin ? p_cond_q[3:1] : cond_i[3:1];

  calu_cond u_cond (
    .sel_i  (sel),
    .flags_i(flags_q),
    .pass_o (pass)
  );

  always_comb begin
    f_done = 1'b0;
    f_wr   = 1'b0;
    f_upd  = 1'b0;
    f_err  = 1'b0;
    f_res  = res_l;
    if (div_fin) begin
      f_done = 1'b1;
      f_res  = p_mod_q ? rem : quot;
      f_wr   = pass;
      f_upd  = p_cond_q[0];
      f_err  = p_dz_q;
    end else if (accept && !is_div) begin
      f_done = 1'b1;
      f_wr   = pass && writes_l;
      f_upd  = legal_l && cond_i[0];
    end
  end

  always_comb begin
    flags_n = flags_q;
    if (accept && !is_div && cmp_l) begin
      flags_n.lt = $signed(src_a_i) < $signed(src_b_i);
      flags_n.eq = src_a_i == src_b_i;
    end else if (f_upd) begin
      flags_n.lt = f_res[W-1];
      flags_n.eq = f_res == '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      wr_q     <= 1'b0;
      err_q    <= 1'b0;
      res_q    <= '0;
      flags_q  <= '0;
      p_cond_q <= '0;
      p_mod_q  <= 1'b0;
      p_dz_q   <= 1'b0;
    end else begin
      done_q  <= f_done;
      wr_q    <= f_wr;
      err_q   <= f_err;
      flags_q <= flags_n;
      if (f_done) res_q <= f_res;
      if (accept && is_div) begin
        busy_q   <= 1'b1;
        p_cond_q <= cond_i;
        p_mod_q  <= (op == OP_MOD);
        p_dz_q   <= (src_b_i == '0);
      end else if (div_fin) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign result_o  = res_q;
  assign wr_en_o   = wr_q;
  assign done_o    = done_q;
  assign busy_o    = busy_q;
  assign div_err_o = err_q;
  assign flags_o   = {flags_q.lt, flags_q.eq};
endmodule

// File: rtl/calu_checker.sv
module calu_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic [3:0]   op_i,
  input logic [3:0]   cond_i,
  input logic [7:0]   sub_i,
  input logic [W-1:0] src_a_i,
  input logic [W-1:0] src_b_i,
  input logic [W-1:0] result_o,
  input logic         wr_en_o,
  input logic         done_o,
  input logic         busy_o,
  input logic         div_err_o,
  input logic [1:0]   flags_o
);
  p_single_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !busy_o && op_i < 4'd14 |=> done_o && !busy_o);

  p_cmp_no_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !busy_o && op_i == 4'd1 && sub_i == 8'h00 |=> !wr_en_o);

  p_write_with_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> done_o);

  p_always_writes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !busy_o && cond_i[3:1] == 3'd0 && op_i != 4'd1 && op_i < 4'd14
    |=> wr_en_o);

  p_flags_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(flags_o));

  p_div_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !busy_o && op_i >= 4'd14 |=> busy_o && !done_o);

  p_err_with_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |-> done_o);

  p_busy_no_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
endmodule

bind cond_alu16 calu_checker #(.W(W)) u_chk (.*);

// File: tb/sim_cond_alu16.sv
module sim_cond_alu16;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [3:0]  op = '0, cond = '0;
  logic [7:0]  sub = '0;
  logic [15:0] a = '0, b = '0;
  logic [15:0] result;
  logic        wr_en, done, busy, div_err;
  logic [1:0]  flags;

  int checks = 0;
  int errors = 0;
  logic m_lt = 1'b0, m_eq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_alu16 u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .cond_i(cond),
    .sub_i(sub), .src_a_i(a), .src_b_i(b), .result_o(result), .wr_en_o(wr_en),
    .done_o(done), .busy_o(busy), .div_err_o(div_err), .flags_o(flags)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s op=%0d cond=%0h sub=%0h a=%h b=%h: actual %h expected %h",
               req, what, op, cond, sub, a, b, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic bit cond_ok(input logic [2:0] s, input logic lt, input logic eq);
    case (s)
      3'd0: return 1'b1;
      3'd1: return lt;
      3'd2: return lt | eq;
      3'd3: return eq;
      3'd4: return !lt;
      3'd5: return !lt && !eq;
      3'd6: return !eq;
      default: return 1'b0;
    endcase
  endfunction

  // R1 .. R10 reference behaviour, independent of the RTL
  task automatic issue(input logic [3:0] o, input logic [3:0] c, input logic [7:0] s,
                       input logic [15:0] x, input logic [15:0] y);
    logic [15:0] e_res;
    bit e_wr, legal, is_cmp, e_err, is_div;
    logic [31:0] rot;
    longint ps;
    int sh;
    string rq;
    sh = int'(y[3:0]);
    legal = 1; is_cmp = 0; e_err = 0; e_res = '0;
    is_div = o >= 4'd14;
    rq = "R3";
    case (o)
      4'd0:  e_res = x;
      4'd1: begin
        rq = (s == 8'h00) ? "R6" : "R5";
        case (s)
          8'h00: is_cmp = 1;
          8'h01: e_res = ~x;
          8'h02: e_res = 16'(-int'(x));
          8'h03: e_res = (x == 0) ? 16'd1 : 16'd0;
          default: legal = 0;
        endcase
      end
      4'd2:  e_res = x | y;
      4'd3:  e_res = x & y;
      4'd4:  e_res = x ^ y;
      4'd5:  begin rq = "R4"; e_res = x >> sh; end
      4'd6:  begin rq = "R4"; e_res = 16'($signed(x) >>> sh); end
      4'd7:  begin rq = "R4"; e_res = 16'(x << sh); end
      4'd8:  begin rq = "R4"; rot = {x, x} << sh; e_res = rot[31:16]; end
      4'd9:  e_res = 16'(int'(x) + int'(y));
      4'd10: e_res = 16'(int'(x) - int'(y));
      4'd11: e_res = 16'(int'(x) * int'(y));
      4'd12: begin ps = longint'($signed(x)) * longint'($signed(y)); e_res = ps[31:16]; end
      4'd13: begin ps = longint'(x) * longint'(y); e_res = ps[31:16]; end
      4'd14: begin rq = (y == 0) ? "R10" : "R9"; e_res = (y == 0) ? 16'hFFFF : x / y; e_err = (y == 0); end
      default: begin rq = (y == 0) ? "R10" : "R9"; e_res = (y == 0) ? x : x % y; e_err = (y == 0); end
    endcase
    e_wr = legal && !is_cmp && cond_ok(c[3:1], m_lt, m_eq);

    @(negedge clk);
    valid = 1; op = o; cond = c; sub = s; a = x; b = y;
    @(negedge clk);
    valid = 0;
    if (is_div) begin
      chk(busy === 1'b1 && done === 1'b0, "R9", "busy after start", {busy, done}, 2'b10);
      for (int i = 0; i < 64 && done !== 1'b1; i++) @(negedge clk);
    end else begin
      chk(busy === 1'b0, "R2", "busy", busy, 0);
    end
    chk(done === 1'b1, is_div ? "R9" : "R2", "done", done, 1);
    chk(wr_en === e_wr, is_cmp ? "R6" : "R7", "wr_en", wr_en, e_wr);
    if (e_wr) chk(result === e_res, rq, "result", result, e_res);
    chk(div_err === e_err, "R10", "div_err", div_err, e_err);

    if (is_cmp) begin
      m_lt = $signed(x) < $signed(y);
      m_eq = (x == y);
    end else if (legal && c[0]) begin
      m_lt = e_res[15];
      m_eq = (e_res == 0);
    end
    chk(flags === {m_lt, m_eq}, is_cmp ? "R6" : (legal ? "R8" : "R5"), "flags",
        flags, {m_lt, m_eq});
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] vals [8];
    logic [7:0]  subs [6];
    vals = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0013, 16'hA5C3};
    subs = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'hFF};

    #(CLK_PERIOD * 2 + 1);
    // R1 reset state
    chk(result === 16'h0 && flags === 2'b00, "R1", "reset data", {result, flags}, 0);
    chk({wr_en, done, busy, div_err} === 4'b0, "R1", "reset ctrl",
        {wr_en, done, busy, div_err}, 0);
    rst_n = 1;

    for (int o = 0; o < 16; o++)
      for (int c = 0; c < 16; c++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            if (o != 1) issue(4'(o), 4'(c), 8'h00, vals[i], vals[j]);

    for (int s = 0; s < 6; s++)
      for (int c = 0; c < 16; c++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++)
            issue(4'd1, 4'(c), subs[s], vals[i], vals[j]);

    // R4 upper shift bits ignored
    for (int k = 0; k < 16; k++) issue(4'(5 + (k % 4)), 4'd0, 8'h00, 16'hC3A5, 16'(16'hFFF0 | k));

    for (int k = 0; k < 400; k++)
      issue(4'($urandom), 4'($urandom), 8'($urandom % 5), 16'($urandom), 16'($urandom));

    // R11 offer a flag-refreshing load while the divider runs
    issue(4'd9, 4'd1, 8'h00, 16'h0001, 16'h0000);
    @(negedge clk);
    valid = 1; op = 4'd14; cond = 4'd1; sub = 0; a = 16'd100; b = 16'd7;
    @(negedge clk);
    op = 4'd0; a = 16'h0000; cond = 4'd1;
    @(negedge clk);
    valid = 0;
    for (int i = 0; i < 64 && done !== 1'b1; i++) @(negedge clk);
    chk(result === 16'd14 && wr_en === 1'b1, "R11", "div result", result, 14);
    chk(flags === 2'b00, "R11", "flags untouched by ignored load", flags, 0);
    @(negedge clk);
    chk(done === 1'b0, "R11", "no extra completion", done, 0);

    finish_run();
  end
endmodule